// File: doc/BRIEF.md
# In-Lane Vector Pair Permute Unit

This unit reorders 64-bit elements of a vector up to 512 bits wide without letting any element leave its 128-bit lane. Each lane holds a pair of elements, and each destination element takes either the low or the high member of its own pair. The choice comes from one of two places. In immediate mode it is an 8-bit constant with one bit per destination element. In vector mode it is a control vector in which bit 1 of each 64-bit element selects for that element.

Around the selection the unit applies a write mask with merge or zero policy. It can replicate one 64-bit operand value across all elements. It clears every result bit above the active vector length of 128, 256 or 512 bits. It also detects two illegal-encoding conditions. When an encoding is illegal, the fault flag is raised and the old destination comes back unchanged. Inputs arrive with a valid strobe, and the result, valid and fault come back from registers one clock later.

Top module: `lane_pair_permute`

## Requirements
- R1: Destination element j (bits 64j+63:64j) is source element 2*(j/2) when its control bit is 0 and source element 2*(j/2)+1 when it is 1, so selection stays inside its 128-bit lane.
- R2: With `use_imm`=1, bit j of `imm` is the control bit of element j; immediate bits for elements beyond the active count have no effect on the result.
- R3: With `use_imm`=0, the control bit of element j is bit 64j+1 of `src_ctrl`; every other bit of `src_ctrl` has no effect.
- R4: When `bcast`=1, `src_is_mem`=1 and `legacy`=0, bits 63:0 of the operand are copied into every element before use: of `src_data` in immediate mode, of `src_ctrl` in vector mode.
- R5: When `mask_en`=1 and `legacy`=0, an element with `mask[j]`=0 takes `old_dest` element j if `zero_mode`=0 and zero if `zero_mode`=1; mask bits at or beyond the active element count have no effect.
- R6: `vlen` 2'b00 = 128 bits (2 elements), 2'b01 = 256 bits (4), 2'b10 or 2'b11 = 512 bits (8); all result bits from the active length up to bit 511 are zero.
- R7: With `use_imm`=1, `spec_field` other than 4'b1111 raises the fault.
- R8: With `legacy`=1, `wide_bit`=1 raises the fault; a legacy operation ignores `mask_en`, `mask` and `bcast`.
- R9: `out_valid` is `in_valid` delayed by one clock; `out_data` and `out_fault` change only on cycles after `in_valid`=1 and hold otherwise.
- R10: When the fault is raised, `out_fault`=1 in the same cycle as `out_valid`, and `out_data` equals all 512 bits of `old_dest`.
- R11: Synchronous reset `rst`=1 clears `out_valid`, `out_fault` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| use_imm | input | 1 | 1 = immediate control, 0 = vector control |
| vlen | input | 2 | Active vector length code |
| imm | input | 8 | Immediate control bits |
| src_data | input | 512 | Data operand |
| src_ctrl | input | 512 | Control vector |
| src_is_mem | input | 1 | Operand comes from memory |
| bcast | input | 1 | Broadcast request |
| mask_en | input | 1 | Write masking enabled |
| mask | input | 8 | Per-element write mask |
| zero_mode | input | 1 | 1 = zero masked elements, 0 = merge |
| legacy | input | 1 | Legacy non-masked encoding |
| wide_bit | input | 1 | Width bit of the legacy encoding |
| spec_field | input | 4 | Extra register-specifier field |
| old_dest | input | 512 | Prior destination value |
| out_valid | output | 1 | Result strobe |
| out_data | output | 512 | Result vector |
| out_fault | output | 1 | Illegal-encoding fault |

## Verification
Masking and length truncation can act on the same element in one operation. A 128-bit operation with a mask that clears high bits must still zero the upper elements instead of merging old data into them. The random stream also lets a fault coincide with broadcast and masking, and the result must then be the untouched old destination. Each vector is compared against a bench model that applies broadcast, selection, masking, truncation and fault in that order.

// File: rtl/lpp_pkg.sv
package lpp_pkg;
  localparam int ELEM_W    = 64;
  localparam int MAX_ELEMS = 8;
  localparam int VEC_W     = ELEM_W * MAX_ELEMS;

  typedef enum logic [1:0] {
    VL_128 = 2'b00,
    VL_256 = 2'b01,
    VL_512 = 2'b10,
    VL_MAX = 2'b11
  } vlen_e;

  // Active element count for a length code, clipped to the vector size.
  function automatic int active_elems(input logic [1:0] code, input int ne);
    int n;
    n = 2 << code;
    return (n > ne) ? ne : n;
  endfunction
endpackage

// File: rtl/lpp_bcast.sv
module lpp_bcast #(
  parameter int EW = 64,
  parameter int NE = 8
) (
  input  logic [EW*NE-1:0] vec_in,
  input  logic             rep_en,
  output logic [EW*NE-1:0] vec_out
);
  genvar g;
  generate
    for (g = 0; g < NE; g++) begin : g_rep
      assign vec_out[g*EW +: EW] = rep_en ? vec_in[EW-1:0] : vec_in[g*EW +: EW];
    end
  endgenerate
endmodule

// File: rtl/lpp_select.sv
module lpp_select #(
  parameter int EW = 64,
  parameter int NE = 8
) (
  input  logic [EW*NE-1:0] data_in,
  input  logic [NE-1:0]    pick_hi,
  output logic [EW*NE-1:0] data_out
);
  localparam int PAIRS = NE / 2;

  genvar p, h;
  generate
    for (p = 0; p < PAIRS; p++) begin : g_pair
      for (h = 0; h < 2; h++) begin : g_half
        localparam int DST = 2*p + h;
        assign data_out[DST*EW +: EW] = pick_hi[DST] ? data_in[(2*p+1)*EW +: EW]
                                                     : data_in[(2*p)*EW +: EW];
      end
    end
  endgenerate
endmodule

// File: rtl/lpp_mask.sv
module lpp_mask #(
  parameter int EW = 64,
  parameter int NE = 8
) (
  input  logic [EW*NE-1:0] perm,
  input  logic [EW*NE-1:0] prior,
  input  logic [NE-1:0]    wmask,
  input  logic             wmask_on,
  input  logic             zeroing,
  input  logic [1:0]       len_code,
  output logic [EW*NE-1:0] result
);
  import lpp_pkg::*;

  int n_act;
  always_comb n_act = active_elems(len_code, NE);

  genvar g;
  generate
    for (g = 0; g < NE; g++) begin : g_elem
      always_comb begin
        if (g >= n_act)
          result[g*EW +: EW] = '0;
        else if (!wmask_on || wmask[g])
          result[g*EW +: EW] = perm[g*EW +: EW];
        else if (zeroing)
          result[g*EW +: EW] = '0;
        else
          result[g*EW +: EW] = prior[g*EW +: EW];
      end
    end
  endgenerate
endmodule

// File: rtl/lane_pair_permute.sv
module lane_pair_permute #(
  parameter int EW = lpp_pkg::ELEM_W,
  parameter int NE = lpp_pkg::MAX_ELEMS,
  localparam int VW = EW * NE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          use_imm,
  input  logic [1:0]    vlen,
  input  logic [NE-1:0] imm,
  input  logic [VW-1:0] src_data,
  input  logic [VW-1:0] src_ctrl,
  input  logic          src_is_mem,
  input  logic          bcast,
  input  logic          mask_en,
  input  logic [NE-1:0] mask,
  input  logic          zero_mode,
  input  logic          legacy,
  input  logic          wide_bit,
  input  logic [3:0]    spec_field,
  input  logic [VW-1:0] old_dest,
  output logic          out_valid,
  output logic [VW-1:0] out_data,
  output logic          out_fault
);
  logic          rep_ok, rep_data, rep_ctrl;
  logic [VW-1:0] data_b, ctrl_b, perm_v, masked_v;
  logic [NE-1:0] hi_sel;
  logic          bad_enc;

  assign rep_ok   = bcast && src_is_mem && !legacy;
  assign rep_data = rep_ok && use_imm;
  assign rep_ctrl = rep_ok && !use_imm;

  lpp_bcast #(.EW(EW), .NE(NE)) u_bc_data (
    .vec_in(src_data), .rep_en(rep_data), .vec_out(data_b));

  lpp_bcast #(.EW(EW), .NE(NE)) u_bc_ctrl (
    .vec_in(src_ctrl), .rep_en(rep_ctrl), .vec_out(ctrl_b));

  genvar g;
  generate
    for (g = 0; g < NE; g++) begin : g_ctl
      assign hi_sel[g] = use_imm ? imm[g] : ctrl_b[g*EW + 1];
    end
  endgenerate

  lpp_select #(.EW(EW), .NE(NE)) u_sel (
    .data_in(data_b), .pick_hi(hi_sel), .data_out(perm_v));

  lpp_mask #(.EW(EW), .NE(NE)) u_msk (
    .perm(perm_v), .prior(old_dest), .wmask(mask),
    .wmask_on(mask_en && !legacy), .zeroing(zero_mode),
    .len_code(vlen), .result(masked_v));

  assign bad_enc = (use_imm && (spec_field != 4'b1111)) || (legacy && wide_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault <= bad_enc;
        out_data  <= bad_enc ? old_dest : masked_v;
      end
    end
  end
endmodule

// File: rtl/lpp_checker.sv
module lpp_checker #(
  parameter int EW = 64,
  parameter int NE = 8,
  localparam int VW = EW * NE
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          use_imm,
  input logic [1:0]    vlen,
  input logic [NE-1:0] mask,
  input logic          mask_en,
  input logic          zero_mode,
  input logic          legacy,
  input logic          wide_bit,
  input logic [3:0]    spec_field,
  input logic [VW-1:0] old_dest,
  input logic          out_valid,
  input logic [VW-1:0] out_data,
  input logic          out_fault
);
  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_fault && out_data == '0));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(out_data) && $stable(out_fault)));

  assert_spec_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && use_imm && spec_field != 4'b1111) |=> (out_fault && out_valid));

  assert_legacy_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy && wide_bit) |=> out_fault);

  assert_fault_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && use_imm && spec_field != 4'b1111) |=> (out_data == $past(old_dest)));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen == 2'b00) |=> (out_fault || out_data[VW-1:2*EW] == '0));

  assert_mask_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !legacy && zero_mode && !mask[0]) |=>
      (out_fault || out_data[EW-1:0] == '0));

  assert_mask_merge_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !legacy && !zero_mode && !mask[0]) |=>
      (out_fault || out_data[EW-1:0] == $past(old_dest[EW-1:0])));
endmodule

bind lane_pair_permute lpp_checker #(.EW(EW), .NE(NE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .use_imm(use_imm), .vlen(vlen),
  .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .legacy(legacy),
  .wide_bit(wide_bit), .spec_field(spec_field), .old_dest(old_dest),
  .out_valid(out_valid), .out_data(out_data), .out_fault(out_fault));

// File: tb/lane_pair_permute_tb.sv
`timescale 1ns/1ps
module lane_pair_permute_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0, use_imm = 1'b0, src_is_mem = 1'b0, bcast = 1'b0;
  logic [1:0]   vlen = '0;
  logic [7:0]   imm = '0, mask = '0;
  logic [511:0] src_data = '0, src_ctrl = '0, old_dest = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, legacy = 1'b0, wide_bit = 1'b0;
  logic [3:0]   spec_field = 4'hF;
  logic         out_valid, out_fault;
  logic [511:0] out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_pair_permute u_dut (.*);

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic exp_fault();
    return (use_imm && spec_field != 4'hF) || (legacy && wide_bit);
  endfunction

  function automatic logic [511:0] exp_data();
    logic [511:0] r;
    logic [63:0]  lo, hi;
    int  n;
    logic rep, c;
    if (exp_fault()) return old_dest;
    n   = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
    rep = bcast && src_is_mem && !legacy;
    r   = '0;
    for (int j = 0; j < n; j++) begin
      if (use_imm) c = imm[j];
      else c = (rep ? src_ctrl[1] : src_ctrl[j*64 + 1]);
      if (use_imm && rep) begin
        lo = src_data[63:0]; hi = src_data[63:0];
      end else begin
        lo = src_data[(j/2)*128 +: 64]; hi = src_data[(j/2)*128 + 64 +: 64];
      end
      if (!mask_en || legacy || mask[j]) r[j*64 +: 64] = c ? hi : lo;
      else if (zero_mode) r[j*64 +: 64] = '0;
      else r[j*64 +: 64] = old_dest[j*64 +: 64];
    end
    return r;
  endfunction

  task automatic check_eq(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag);
    logic [511:0] ed;
    logic ef;
    @(negedge clk);
    in_valid = 1'b1;
    ed = exp_data();
    ef = exp_fault();
    @(negedge clk);
    in_valid = 1'b0;
    check_eq({tag, " valid"}, {511'd0, out_valid}, 512'd1);
    check_eq({tag, " fault"}, {511'd0, out_fault}, {511'd0, ef});
    check_eq({tag, " data"}, out_data, ed);
  endtask

  task automatic defaults();
    use_imm = 1'b1; vlen = 2'b10; imm = '0; mask = 8'hFF; mask_en = 1'b0;
    zero_mode = 1'b0; legacy = 1'b0; wide_bit = 1'b0; spec_field = 4'hF;
    src_is_mem = 1'b0; bcast = 1'b0;
    src_data = rnd512(); src_ctrl = rnd512(); old_dest = rnd512();
  endtask

  initial begin
    logic [511:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R11 reset valid", {511'd0, out_valid}, 512'd0);
    check_eq("R11 reset data", out_data, 512'd0);

    defaults(); imm = 8'b1010_1010; run("R1 alternate imm");
    defaults(); imm = 8'b0101_0101; run("R1 swap imm");
    defaults(); vlen = 2'b00; imm = 8'b1111_1101; run("R2 high imm bits ignored");
    defaults(); use_imm = 1'b0; spec_field = 4'h3;
    src_ctrl = rnd512(); run("R3 vector control, spec ignored");
    defaults(); use_imm = 1'b0; src_ctrl = {8{64'hFFFF_FFFF_FFFF_FFFD}}; run("R3 only bit1 matters");
    defaults(); bcast = 1'b1; src_is_mem = 1'b1; imm = 8'h5A; run("R4 bcast data");
    defaults(); use_imm = 1'b0; bcast = 1'b1; src_is_mem = 1'b1; src_ctrl[1] = 1'b1; run("R4 bcast ctrl");
    defaults(); bcast = 1'b1; src_is_mem = 1'b0; imm = 8'hC3; run("R4 no bcast from register");
    defaults(); mask_en = 1'b1; mask = 8'h96; zero_mode = 1'b0; run("R5 merge");
    defaults(); mask_en = 1'b1; mask = 8'h96; zero_mode = 1'b1; run("R5 zero");
    defaults(); vlen = 2'b00; mask_en = 1'b1; mask = 8'h01; run("R5 R6 mask and length same cycle");
    defaults(); vlen = 2'b01; imm = 8'hFF; run("R6 256-bit upper zero");
    defaults(); vlen = 2'b11; imm = 8'h33; run("R6 code 11 is 512");
    defaults(); spec_field = 4'h7; mask_en = 1'b1; mask = 8'h00; zero_mode = 1'b1; run("R7 R10 spec fault keeps dest");
    defaults(); legacy = 1'b1; wide_bit = 1'b1; run("R8 legacy wide fault");
    defaults(); legacy = 1'b1; mask_en = 1'b1; mask = 8'h00; zero_mode = 1'b1;
    bcast = 1'b1; src_is_mem = 1'b1; vlen = 2'b01; imm = 8'h06; run("R8 legacy ignores mask and bcast");

    defaults(); imm = 8'h3C; run("R9 before idle");
    held = out_data;
    src_data = rnd512(); old_dest = rnd512(); spec_field = 4'h0;
    @(negedge clk);
    check_eq("R9 idle valid low", {511'd0, out_valid}, 512'd0);
    check_eq("R9 idle data held", out_data, held);

    for (int n = 0; n < 400; n++) begin
      defaults();
      use_imm    = $urandom_range(0, 1);
      vlen       = 2'($urandom_range(0, 3));
      imm        = 8'($urandom);
      mask       = 8'($urandom);
      mask_en    = $urandom_range(0, 1);
      zero_mode  = $urandom_range(0, 1);
      legacy     = ($urandom_range(0, 3) == 0);
      wide_bit   = ($urandom_range(0, 3) == 0);
      spec_field = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      bcast      = $urandom_range(0, 1);
      src_is_mem = $urandom_range(0, 1);
      run("R1 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule